// File: doc/BRIEF.md
# Serial-Bus Clock Output Enable Controller

This block is a write-only slave on a two-wire SMBus-style control bus that holds the enable bits of a ten-output clock fanout stage. A fast system clock oversamples the bus clock and data lines. Edge detection on the synchronized lines finds the bus conditions that open and close a transfer. Bytes arrive most significant bit first. The block acknowledges each accepted byte by pulling the data line low through an open-drain enable.

A transfer that the block accepts has a fixed shape. The write address comes first. Two header bytes follow, and they are acknowledged and thrown away. Then come data bytes, which always fill the three control registers from the first one upward. No byte can select a register. To change a later register, the host must resend every register before it. The ten enable outputs are decoded from fixed bit fields of the three registers. A 0 in an enable bit means the clock output is held low.

Top module: `smb_oe_ctrl`

## Requirements
- R1: A START (synchronized SDA falls while SCL is high) opens a transfer, and a STOP (SDA rises while SCL is high) returns the block to idle. Bytes clocked in after a STOP and before the next START are never acknowledged.
- R2: Bits are shifted in on SCL rising edges, most significant bit first. For each accepted byte, the data line reads low during the high phase of the ninth SCL clock.
- R3: Only the first byte value 0xD2 (7-bit address 0x69, R/W bit 0) is acknowledged. Any other first byte is left unacknowledged, including the read form 0xD3. After such a byte, the block changes no register until the next START.
- R4: The two bytes after the address are acknowledged whatever their value, and they have no effect on any register.
- R5: Data bytes are written in arrival order to register 0, then register 1, then register 2.
- R6: Up to 10 data bytes per transfer are acknowledged. Bytes 4 to 10 change nothing. The 11th data byte and every later byte are not acknowledged until a new START.
- R7: After reset, registers 0, 1 and 2 hold 0xFF, 0xFF and 0xC3, so all ten enables are 1.
- R8: The enable outputs are decoded as follows. Bits 3:0 come from register 0 bits 3:0. Bits 9:6 come from register 1 bits 7:4. Bit 5 comes from register 2 bit 7, and bit 4 from register 2 bit 6. All other register bits have no effect.
- R9: The pull-down turns on only while SCL is low, after the falling edge that ends the eighth bit. It turns off after the falling edge that ends the ninth clock.
- R10: A register takes its new value during the acknowledge of its byte. A START or STOP inside a byte discards that byte and leaves every register unchanged. Register values persist from one transfer to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | Open-drain pull-down enable for the data line |
| clk_en_o | output | 10 | Per-output clock enables, 1 = running |

## Verification
Some properties are checked on every cycle. The pull-down may only start while SCL is low, and it stays on until SCL falls, START or STOP arrives. The enable outputs may change only while an acknowledge is being driven. The byte counter may not pass its limit, and the pull-down is never on while idle. Other behaviour can only be shown by the bench scenarios: address matching, dropping the header bytes, the register order, the 10-byte limit, aborted bytes, and the exact enable decoding. The bench sweeps a series of register patterns and compares the enable vector after every data byte.

// File: rtl/smb_oe_pkg.sv
package smb_oe_pkg;

    localparam int          NUM_REGS   = 3;
    localparam int          NUM_OUTS   = 10;
    localparam int          IDX_W      = 2;
    localparam logic [7:0]  DEV_WR_ADR = 8'hD2;

    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_BITS,
        LNK_ACK
    } link_state_t;

    // Synchronized bus view and the events derived from it
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Register write request issued at an acknowledge
    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } reg_wr_t;

    function automatic logic [7:0] reg_reset(input int i);
        case (i)
            0:       return 8'hFF;
            1:       return 8'hFF;
            default: return 8'hC3;
        endcase
    endfunction

    function automatic logic [NUM_OUTS-1:0] map_enables(
        input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] r2);
        return {r1[7:4], r2[7:6], r0[3:0]};
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_oe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] old;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        // pipe[STAGES-1] is the synchronized level, pipe[STAGES] the one before
        logic [STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-1:0], raw[g]};
        end
        assign cur[g] = pipe[STAGES-1];
        assign old[g] = pipe[STAGES];
    end

    always_comb begin
        ev_o.scl      = cur[1];
        ev_o.sda      = cur[0];
        ev_o.scl_rise = cur[1] & ~old[1];
        ev_o.scl_fall = ~cur[1] & old[1];
        ev_o.start    = cur[1] & old[1] & old[0] & ~cur[0];
        ev_o.stop     = cur[1] & old[1] & ~old[0] & cur[0];
    end

endmodule

// File: rtl/smb_link.sv
module smb_link
    import smb_oe_pkg::*;
#(
    parameter int MAX_DATA = 10,
    parameter int SKIP     = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev_i,
    output logic    pull_o,
    output reg_wr_t wr_o
);
    localparam int LAST_IDX = SKIP + MAX_DATA;
    localparam int CNT_W    = $clog2(LAST_IDX + 2);

    link_state_t      state_q;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       shreg_q;
    logic [CNT_W-1:0] byte_no_q;
    logic             pull_q;
    reg_wr_t          wr_q;

    logic             accept;
    logic             data_slot;
    logic [IDX_W-1:0] slot_idx;

    always_comb begin
        if (byte_no_q == '0) accept = (shreg_q == DEV_WR_ADR);
        else                 accept = (byte_no_q <= CNT_W'(LAST_IDX));
        data_slot = (byte_no_q > CNT_W'(SKIP)) &&
                    (byte_no_q <= CNT_W'(SKIP + NUM_REGS));
        slot_idx  = IDX_W'(byte_no_q - CNT_W'(SKIP + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LNK_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            byte_no_q <= '0;
            pull_q    <= 1'b0;
            wr_q      <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (ev_i.start) begin
                state_q   <= LNK_BITS;
                bit_cnt_q <= '0;
                byte_no_q <= '0;
                pull_q    <= 1'b0;
            end else if (ev_i.stop) begin
                state_q <= LNK_IDLE;
                pull_q  <= 1'b0;
            end else begin
                case (state_q)
                    LNK_BITS: begin
                        if (ev_i.scl_rise && bit_cnt_q != 4'd8) begin
                            shreg_q   <= {shreg_q[6:0], ev_i.sda};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (ev_i.scl_fall && bit_cnt_q == 4'd8) begin
                            if (accept) begin
                                state_q <= LNK_ACK;
                                pull_q  <= 1'b1;
                                if (data_slot) begin
                                    wr_q.en   <= 1'b1;
                                    wr_q.idx  <= slot_idx;
                                    wr_q.data <= shreg_q;
                                end
                            end else begin
                                state_q <= LNK_IDLE;
                            end
                        end
                    end
                    LNK_ACK: begin
                        if (ev_i.scl_fall) begin
                            pull_q    <= 1'b0;
                            state_q   <= LNK_BITS;
                            bit_cnt_q <= '0;
                            byte_no_q <= byte_no_q + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pull_o = pull_q;
    assign wr_o   = wr_q;

    assert_ack_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_q) |-> !ev_i.scl);

    assert_ack_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (pull_q && !ev_i.scl_fall && !ev_i.start && !ev_i.stop) |=> pull_q);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == LNK_IDLE) |-> !pull_q);

    assert_byte_limit_R6: assert property (@(posedge clk) disable iff (rst)
        byte_no_q <= CNT_W'(LAST_IDX + 1));

endmodule

// File: rtl/smb_oe_regs.sv
module smb_oe_regs
    import smb_oe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  reg_wr_t             wr_i,
    output logic [NUM_OUTS-1:0] en_o
);
    logic [NUM_REGS-1:0][7:0] regs;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                     q <= reg_reset(i);
            else if (wr_i.en && wr_i.idx == IDX_W'(i))  q <= wr_i.data;
        end
        assign regs[i] = q;
    end

    assign en_o = map_enables(regs[0], regs[1], regs[2]);

    assert_wr_index_R5: assert property (@(posedge clk) disable iff (rst)
        wr_i.en |-> (wr_i.idx < IDX_W'(NUM_REGS)));

endmodule

// File: rtl/smb_oe_ctrl.sv
module smb_oe_ctrl
    import smb_oe_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int MAX_DATA_BYTES = 10,
    parameter int HEADER_BYTES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [9:0] clk_en_o
);
    bus_ev_t ev;
    reg_wr_t wr;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    smb_link #(.MAX_DATA(MAX_DATA_BYTES), .SKIP(HEADER_BYTES)) u_link (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (ev),
        .pull_o (sda_pull_o),
        .wr_o   (wr)
    );

    smb_oe_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr_i (wr),
        .en_o (clk_en_o)
    );

    assert_update_in_ack_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_en_o) |-> sda_pull_o);

endmodule

// File: tb/smb_oe_ctrl_tb.sv
module smb_oe_ctrl_tb;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic [9:0] clk_en;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    logic [7:0] mr [3];

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    smb_oe_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .clk_en_o   (clk_en)
    );

    function automatic logic [9:0] exp_en();
        return {mr[1][7:4], mr[2][7], mr[2][6], mr[0][3:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = ~sda_line;
        wait_q();
        scl_m = 1'b0; wait_q();
        // R9: pull-down released after the falling edge ending the ninth clock
        check("R9 pull released", {31'd0, sda_pull}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        mr[0] = 8'hFF; mr[1] = 8'hFF; mr[2] = 8'hC3;

        // R7: reset values
        check("R7 reset enables", {22'd0, clk_en}, 32'h3FF);
        check("R7 reset pull", {31'd0, sda_pull}, 32'd0);

        // R3: other write address and the read form are ignored
        bus_start(); send_byte(8'hD0, ack);
        check("R3 other address nack", {31'd0, ack}, 32'd0);
        send_byte(8'h00, ack);
        check("R3 no ack after bad address", {31'd0, ack}, 32'd0);
        bus_stop();
        bus_start(); send_byte(8'hD3, ack);
        check("R3 read nack", {31'd0, ack}, 32'd0);
        send_byte(8'h00, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        bus_stop();
        check("R3 registers unchanged", {22'd0, clk_en}, {22'd0, exp_en()});

        // R5 R8 R4 R10: sweep of register patterns, header bytes varied
        for (int k = 0; k < 16; k++) begin
            logic [7:0] d [3];
            d[0] = {4'(k ^ 5), 4'(k)};
            d[1] = {4'(~k), 4'(k)};
            d[2] = {2'(k >> 1), 6'(k * 7)};
            bus_start();
            send_byte(8'hD2, ack);
            check("R3 write address ack", {31'd0, ack}, 32'd1);
            send_byte(8'(k * 17), ack);
            check("R4 command byte ack", {31'd0, ack}, 32'd1);
            send_byte(8'(255 - k), ack);
            check("R4 count byte ack", {31'd0, ack}, 32'd1);
            check("R4 header bytes no effect", {22'd0, clk_en}, {22'd0, exp_en()});
            for (int j = 0; j < 3; j++) begin
                send_byte(d[j], ack);
                check("R2 data ack", {31'd0, ack}, 32'd1);
                mr[j] = d[j];
                // R5 R8 R10: enable decoding updated at this byte's acknowledge
                check("R5 R8 R10 enables after data byte", {22'd0, clk_en}, {22'd0, exp_en()});
            end
            bus_stop();
        end

        // R10: persistence; writing register 0 only leaves 1 and 2
        bus_start(); send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h01, ack);
        send_byte(8'h0A, ack); mr[0] = 8'h0A; bus_stop();
        check("R10 partial write persists", {22'd0, clk_en}, {22'd0, exp_en()});

        // R6: ten data bytes acked, eleventh refused, later ignored
        bus_start(); send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h0A, ack);
        for (int j = 0; j < 10; j++) begin
            v = (j == 0) ? 8'h05 : (j == 1) ? 8'h90 : (j == 2) ? 8'h40 : 8'h00;
            send_byte(v, ack);
            check("R6 data byte within limit acked", {31'd0, ack}, 32'd1);
            if (j < 3) mr[j] = v;
            check("R6 extra bytes no effect", {22'd0, clk_en}, {22'd0, exp_en()});
        end
        send_byte(8'hFF, ack);
        check("R6 eleventh byte nack", {31'd0, ack}, 32'd0);
        send_byte(8'hD2, ack);
        check("R6 idle until START", {31'd0, ack}, 32'd0);
        bus_stop();
        check("R6 registers after overflow", {22'd0, clk_en}, {22'd0, exp_en()});

        // R1: bytes after STOP without START are not acknowledged
        scl_m = 1'b0; wait_q();
        send_byte(8'hD2, ack);
        check("R1 no ack without START", {31'd0, ack}, 32'd0);
        send_byte(8'h00, ack);
        bus_stop();

        // R10: STOP inside a data byte aborts it
        bus_start(); send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_byte(8'hF3, ack); mr[0] = 8'hF3;
        for (int i = 7; i >= 4; i--) put_bit(1'b0);
        bus_stop();
        check("R10 aborted byte by STOP", {22'd0, clk_en}, {22'd0, exp_en()});

        // R10 R1: repeated START inside a data byte aborts it and opens a new transfer
        bus_start(); send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        for (int i = 7; i >= 3; i--) put_bit(1'b0);
        bus_start();
        check("R10 aborted byte by START", {22'd0, clk_en}, {22'd0, exp_en()});
        send_byte(8'hD2, ack);
        check("R1 repeated START ack", {31'd0, ack}, 32'd1);
        send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_byte(8'h00, ack); mr[0] = 8'h00;
        send_byte(8'h00, ack); mr[1] = 8'h00;
        send_byte(8'h80, ack); mr[2] = 8'h80;
        bus_stop();
        check("R8 single output 5 enabled", {22'd0, clk_en}, 32'h020);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule